// File: doc/BRIEF.md
# Energy Efficient Ethernet Low-Power Idle Controller

This block decides when the transmit side of an Ethernet MAC may signal low-power idle (LPI) to the PHY and when it must return to normal operation. Software programs two registers over a simple register bus. The control/status register carries an enable, a link-up flag and an automatic-exit flag, plus four sticky event bits. The timer register holds a link-stable time in milliseconds and a wake time in microseconds. Free-running microsecond and millisecond tick pulses come in as inputs. The block uses them to measure both waits without any divider of its own.

LPI is asserted only in three cases together: the link-up flag has stayed set for the programmed number of millisecond ticks, LPI is enabled, and no frame waits to be sent. When LPI ends, the hold toward the transmit datapath stays asserted until the wake time has elapsed. If the link is reported down, LPI ends at once and the stability count starts again. The link partner's receive-side LPI state comes in on a pin, and the block records its edges. Every recorded event raises an interrupt, and a read of the control/status register clears the interrupt.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset `lpi_tx`, `tx_hold` and `lpi_irq` are low, and both registers read as zero.
- R2: Address 1 is the timer register. Bits 15:0 hold the wake time and bits 26:16 hold the link-stable time. All other bits read as zero. Address 0 is the control/status register: bit 16 enable, bit 17 link-up, bit 19 automatic exit, bit 0 transmit-entry event, bit 1 transmit-exit event, bit 2 receive-entry event, bit 3 receive-exit event, bit 8 transmit LPI active, bit 9 registered receive LPI state. Writes to other addresses change nothing, and reads of other addresses return zero.
- R3: `lpi_tx` does not rise until the link-up bit has been set for at least LS millisecond ticks. It rises on the clock edge after the edge that samples the LS-th tick.
- R4: LPI is entered only on an edge where `tx_pending` is low.
- R5: Clearing the link-up bit while LPI is active drops `lpi_tx` one edge after the write. The stability count then restarts from zero, so re-entry needs LS new ticks after link-up is set again.
- R6: After `lpi_tx` falls, `tx_hold` stays high until TW microsecond ticks have been counted. It falls on the edge after the edge that samples the TW-th tick.
- R7: With automatic exit set, a pending frame ends LPI one edge after it is seen. With automatic exit clear, a pending frame leaves LPI in place.
- R8: Clearing the enable bit (forced mode is enable and automatic exit written together; clearing both) ends LPI one edge after the write.
- R9: The event bits are sticky. Each is set on the edge where its event occurs. A read of address 0 clears all of them on that edge, except an event that occurs on the same edge, which stays set.
- R10: A rising edge on `rx_lpi_in` sets the receive-entry event and a falling edge sets the receive-exit event, each on the first edge that samples the change.
- R11: `lpi_irq` is high on each cycle after an edge that leaves any event bit set. It is low after a read of address 0 on which no new event occurs.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of address 0 clears events) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the addressed register |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tx_pending | input | 1 | A transmit frame is waiting |
| rx_lpi_in | input | 1 | Link partner currently in LPI |
| lpi_tx | output | 1 | Assert LPI toward the transmit datapath |
| tx_hold | output | 1 | Normal transmission not allowed (LPI or wake wait) |
| lpi_irq | output | 1 | Any event bit set |

## Verification
Register writes take effect on the write edge. Every state change that follows from them lands on the next edge, so `lpi_tx` and `tx_hold` are sampled one full cycle after the write, or after the last needed tick. The directed tests also sample once just before that cycle, to confirm the output has not moved early. Read data is combinational: the bench samples it with the read strobe held, shortly after a falling edge. Event bits and the interrupt are checked on the next read, or one cycle after the stimulus. All inputs change on falling edges, and all outputs are sampled away from the rising edge.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    localparam int REG_W       = 32;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_TIMER  = 1;
    localparam int BIT_TXSTATE = 8;
    localparam int BIT_RXSTATE = 9;
    localparam int BIT_ENABLE  = 16;
    localparam int BIT_LINK    = 17;
    localparam int BIT_AUTO    = 19;
    localparam int LS_LSB      = 16;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    // bit 0 tx entry, bit 1 tx exit, bit 2 rx entry, bit 3 rx exit
    typedef struct packed {
        logic rx_exit;
        logic rx_entry;
        logic tx_exit;
        logic tx_entry;
    } lpi_events_t;

    typedef struct packed {
        logic auto_exit;
        logic link_up;
        logic enable;
    } lpi_cfg_t;

    function automatic logic [REG_W-1:0] pack_ctrl(
        input lpi_cfg_t    cfg,
        input lpi_events_t ev,
        input logic        tx_st,
        input logic        rx_st
    );
        logic [REG_W-1:0] r;
        r              = '0;
        r[3:0]         = ev;
        r[BIT_TXSTATE] = tx_st;
        r[BIT_RXSTATE] = rx_st;
        r[BIT_ENABLE]  = cfg.enable;
        r[BIT_LINK]    = cfg.link_up;
        r[BIT_AUTO]    = cfg.auto_exit;
        return r;
    endfunction

endpackage

// File: rtl/lpi_tick_timer.sv
module lpi_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt >= limit);
endmodule

// File: rtl/lpi_regs.sv
module lpi_regs
    import lpi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int TW_W   = 16,
    parameter int LS_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  lpi_events_t       events,
    input  logic              tx_state,
    input  logic              rx_state,
    output logic [REG_W-1:0]  rdata,
    output lpi_cfg_t          cfg,
    output logic [TW_W-1:0]   tw,
    output logic [LS_W-1:0]   ls,
    output lpi_events_t       status,
    output logic              irq,
    output logic              rd_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_TIMER = ADDR_W'(ADDR_TIMER);

    lpi_events_t status_n;
    logic        unused_wbits;

    assign unused_wbits = ^wdata;
    assign rd_clr   = rd && (addr == A_CTRL);
    assign status_n = (rd_clr ? lpi_events_t'('0) : status) | events;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            tw     <= '0;
            ls     <= '0;
            status <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr && (addr == A_CTRL)) begin
                cfg.enable    <= wdata[BIT_ENABLE];
                cfg.link_up   <= wdata[BIT_LINK];
                cfg.auto_exit <= wdata[BIT_AUTO];
            end
            if (wr && (addr == A_TIMER)) begin
                tw <= wdata[TW_W-1:0];
                ls <= wdata[LS_LSB +: LS_W];
            end
            status <= status_n;
            irq    <= |status_n;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata = pack_ctrl(cfg, status, tx_state, rx_state);
        end else if (addr == A_TIMER) begin
            rdata[TW_W-1:0]      = tw;
            rdata[LS_LSB +: LS_W] = ls;
        end
    end
endmodule

// File: rtl/lpi_fsm.sv
module lpi_fsm
    import lpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpi_cfg_t   cfg,
    input  logic       link_ok,
    input  logic       wake_done,
    input  logic       tx_pending,
    output lpi_state_e state,
    output logic       entry_ev,
    output logic       exit_ev
);
    lpi_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE: if (cfg.enable && link_ok && !tx_pending) nxt = ST_LPI;
            ST_LPI:    if (!cfg.enable || !cfg.link_up ||
                           (cfg.auto_exit && tx_pending)) nxt = ST_WAKE;
            ST_WAKE:   if (wake_done) nxt = ST_ACTIVE;
            default:   nxt = ST_ACTIVE;
        endcase
    end

    assign entry_ev = (state == ST_ACTIVE) && (nxt == ST_LPI);
    assign exit_ev  = (state == ST_LPI) && (nxt == ST_WAKE);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ACTIVE;
        else     state <= nxt;
    end
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
    import lpi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int TW_W   = 16,
    parameter int LS_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              us_tick,
    input  logic              ms_tick,
    input  logic              tx_pending,
    input  logic              rx_lpi_in,
    output logic              lpi_tx,
    output logic              tx_hold,
    output logic              lpi_irq
);
    lpi_cfg_t    cfg;
    lpi_events_t events;
    lpi_events_t status;
    lpi_state_e  state;
    logic [TW_W-1:0] tw;
    logic [LS_W-1:0] ls;
    logic link_done, link_ok, wake_done;
    logic entry_ev, exit_ev, rd_clr, any_ev;
    logic rx_q;

    always_ff @(posedge clk) begin
        if (rst) rx_q <= 1'b0;
        else     rx_q <= rx_lpi_in;
    end

    assign events.tx_entry = entry_ev;
    assign events.tx_exit  = exit_ev;
    assign events.rx_entry = rx_lpi_in && !rx_q;
    assign events.rx_exit  = !rx_lpi_in && rx_q;
    assign any_ev          = |events;

    lpi_regs #(.ADDR_W(ADDR_W), .TW_W(TW_W), .LS_W(LS_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .events   (events),
        .tx_state (state == ST_LPI),
        .rx_state (rx_q),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .tw       (tw),
        .ls       (ls),
        .status   (status),
        .irq      (lpi_irq),
        .rd_clr   (rd_clr)
    );

    lpi_tick_timer #(.W(LS_W)) u_link_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (!cfg.link_up),
        .tick  (ms_tick),
        .limit (ls),
        .done  (link_done)
    );
    assign link_ok = link_done && cfg.link_up;

    lpi_tick_timer #(.W(TW_W)) u_wake_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (state != ST_WAKE),
        .tick  (us_tick),
        .limit (tw),
        .done  (wake_done)
    );

    lpi_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .link_ok    (link_ok),
        .wake_done  (wake_done),
        .tx_pending (tx_pending),
        .state      (state),
        .entry_ev   (entry_ev),
        .exit_ev    (exit_ev)
    );

    assign lpi_tx  = (state == ST_LPI);
    assign tx_hold = (state != ST_ACTIVE);
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       lpi_tx,
    input logic       tx_hold,
    input logic       tx_pending,
    input logic       link_ok,
    input logic       link_up,
    input logic       rd_clr,
    input logic       any_ev,
    input logic [3:0] status,
    input logic       lpi_irq
);
    // R3
    link_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lpi_tx) |-> $past(link_ok));

    // R4
    idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lpi_tx) |-> $past(!tx_pending));

    // R5
    link_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_up) |=> !lpi_tx);

    // R6
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lpi_tx) |-> tx_hold);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !any_ev) |=> (status == 4'd0));

    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !any_ev) |=> !lpi_irq);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lpi_tx     (lpi_tx),
    .tx_hold    (tx_hold),
    .tx_pending (tx_pending),
    .link_ok    (link_ok),
    .link_up    (cfg.link_up),
    .rd_clr     (rd_clr),
    .any_ev     (any_ev),
    .status     (status),
    .lpi_irq    (lpi_irq)
);

// File: tb/eee_lpi_ctrl_tb.sv
module eee_lpi_ctrl_tb;
    localparam logic [31:0] EN   = 32'h0001_0000;
    localparam logic [31:0] LNK  = 32'h0002_0000;
    localparam logic [31:0] AUTO = 32'h0008_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic us_tick = 1'b0, ms_tick = 1'b0, tx_pending = 1'b0, rx_lpi_in = 1'b0;
    logic lpi_tx, tx_hold, lpi_irq;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eee_lpi_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .us_tick(us_tick), .ms_tick(ms_tick), .tx_pending(tx_pending),
        .rx_lpi_in(rx_lpi_in), .lpi_tx(lpi_tx), .tx_hold(tx_hold),
        .lpi_irq(lpi_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick_ms(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic tick_us(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1; @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tx_pending = 1'b0; rx_lpi_in = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 lpi_tx", {31'd0, lpi_tx}, 32'd0);
        chk("R1 tx_hold", {31'd0, tx_hold}, 32'd0);
        chk("R1 irq", {31'd0, lpi_irq}, 32'd0);
        rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(2'd1, d); chk("R1 timer", d, 32'd0);
    endtask

    task automatic test_regs();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R2 timer fields", d, 32'h07FF_FFFF);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, d); chk("R2 unmapped read", d, 32'd0);
        rd(2'd1, d); chk("R2 unmapped write", d, 32'h07FF_FFFF);
        rd(2'd0, d); chk("R2 ctrl untouched", d, 32'd0);
    endtask

    task automatic test_link_wake();
        logic [31:0] d;
        wr(2'd1, (32'd3 << 16) | 32'd4);
        wr(2'd0, EN | LNK);
        tick_ms(2); cyc(3);
        chk("R3 early", {31'd0, lpi_tx}, 32'd0);
        tick_ms(1);
        chk("R3 not before edge", {31'd0, lpi_tx}, 32'd0);
        cyc(1);
        chk("R3 entry", {31'd0, lpi_tx}, 32'd1);
        chk("R11 irq set", {31'd0, lpi_irq}, 32'd1);
        rd(2'd0, d); chk("R9 entry status", d, 32'h0003_0101);
        chk("R11 irq cleared", {31'd0, lpi_irq}, 32'd0);
        wr(2'd0, EN);
        cyc(1);
        chk("R5 link drop exit", {31'd0, lpi_tx}, 32'd0);
        chk("R6 hold in wake", {31'd0, tx_hold}, 32'd1);
        tick_us(3);
        chk("R6 hold before TW", {31'd0, tx_hold}, 32'd1);
        tick_us(1);
        chk("R6 hold at TW", {31'd0, tx_hold}, 32'd1);
        cyc(1);
        chk("R6 hold released", {31'd0, tx_hold}, 32'd0);
        wr(2'd0, EN | LNK);
        tick_ms(2); cyc(3);
        chk("R5 count restarted", {31'd0, lpi_tx}, 32'd0);
        tick_ms(1); cyc(1);
        chk("R5 re-entry", {31'd0, lpi_tx}, 32'd1);
        rd(2'd0, d); chk("R9 sticky both", d, 32'h0003_0103);
    endtask

    task automatic test_pending();
        logic [31:0] d;
        tx_pending = 1'b1;
        cyc(5);
        chk("R7 no auto exit", {31'd0, lpi_tx}, 32'd1);
        wr(2'd0, EN | LNK | AUTO);
        cyc(1);
        chk("R7 auto exit", {31'd0, lpi_tx}, 32'd0);
        tick_us(4); cyc(6);
        chk("R4 busy blocks entry", {31'd0, lpi_tx}, 32'd0);
        chk("R4 active", {31'd0, tx_hold}, 32'd0);
        tx_pending = 1'b0;
        cyc(1);
        chk("R4 idle entry", {31'd0, lpi_tx}, 32'd1);
        wr(2'd0, LNK);
        cyc(1);
        chk("R8 forced clear exit", {31'd0, lpi_tx}, 32'd0);
        rd(2'd0, d); chk("R9 events", d, 32'h0002_0003);
    endtask

    task automatic test_rx();
        logic [31:0] d;
        do_reset();
        rx_lpi_in = 1'b1;
        cyc(1);
        chk("R11 irq rx", {31'd0, lpi_irq}, 32'd1);
        rd(2'd0, d); chk("R10 rx entry", d, 32'h0000_0204);
        rx_lpi_in = 1'b0;
        cyc(1);
        rd(2'd0, d); chk("R10 rx exit", d, 32'h0000_0008);
        rx_lpi_in = 1'b1;
        rd(2'd0, d); chk("R9 read same edge", d, 32'h0000_0000);
        rd(2'd0, d); chk("R9 event kept", d, 32'h0000_0204);
    endtask

    initial begin
        test_reset();
        test_regs();
        test_link_wake();
        test_pending();
        test_rx();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule